// File: doc/BRIEF.md
# Serial Flash Erase Command Controller

This block is the device-side command logic of a serial NOR flash that handles erasing. A host drives a four-wire serial link (clock, active-low select, data in, data out) in clock mode 0 or mode 3. The block decodes six instructions: write enable, sector erase, block erase, two chip erase codes, and read status. It keeps a write-enable latch and a write-in-progress flag. A three-bit block-protect setting from the surrounding device is compared against each erase target.

Each frame is checked at the moment chip select rises. Only a correctly framed, enabled and unprotected erase starts the self-timed countdown. For the whole countdown the block holds an erase request, with the region kind and the aligned base address, to a behavioural memory array. When the countdown ends, the busy flag and the write-enable latch both clear. The host can poll the status register at any time, including during an erase.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Data is sampled on rising serial clock edges, most significant bit first, and both clock idle levels (mode 0 low, mode 3 high) are accepted.
- R2: Opcode 0x06, framed by chip select rising after exactly 8 bits, sets the write-enable latch (status bit 1). Any other bit count leaves the latch unchanged.
- R3: An erase instruction received while the write-enable latch is 0 starts no erase and leaves the status at its previous value.
- R4: Sector erase (0x20) and block erase (0xD8) are valid only if chip select rises after exactly 32 bits. Chip erase (0x60 or 0xC7) is valid only if it rises after exactly 8 bits. A frame of any other length is discarded and the write-enable latch is kept.
- R5: An accepted erase raises erase_req_o shortly after chip select rises and holds it for exactly SE_CYC, BE_CYC or CE_CYC clock cycles (sector, block, chip).
- R6: When the countdown ends, WIP (status bit 0) and the write-enable latch both return to 0.
- R7: After opcode 0x05, the device returns the status byte MSB first on every following byte, refreshed at each byte boundary: bit 0 WIP, bit 1 write-enable latch, bits 4..2 the protect setting, bits 7..5 zero. This also works during an erase. data_o is 0 while deselected.
- R8: While WIP is 1, every instruction except read status is ignored. A running erase keeps its kind, base and length.
- R9: With protect value p (1..7), the top min(2^(p-1), 8) of the eight 64 KiB blocks are protected. A sector or block erase that addresses them is not executed. A chip erase runs only when p is 0. A refused erase keeps the latch.
- R10: erase_kind_o is 1 for sector, 2 for block and 3 for chip. erase_base_o is the address with its low 12 bits cleared (sector), its low 16 bits cleared (block), or 0 (chip).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, oversamples the serial link |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select |
| data_i | input | 1 | Serial data from the host |
| data_o | output | 1 | Serial data to the host |
| bp_i | input | 3 | Block-protect setting |
| erase_req_o | output | 1 | Erase request to the memory array, high for the erase duration |
| erase_kind_o | output | 2 | Region kind of the current erase |
| erase_base_o | output | 24 | Aligned base address of the erased region |

## Verification
The assertions assume the serial clock runs at least three core cycles per phase, so that every edge is seen after synchronisation. They also assume that bp_i is stable around the rising edge of chip select. The bench toggles the serial clock every six core cycles and changes bp_i only while chip select is high and the link is idle. It drives every frame in both clock modes and reads back the status register through the serial link.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_SECTOR = 2'd1,
    KIND_BLOCK  = 2'd2,
    KIND_CHIP   = 2'd3
  } erase_kind_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE_A = 8'h60;
  localparam logic [7:0] OP_CE_B = 8'hC7;
  localparam logic [7:0] OP_RDSR = 8'h05;
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              data_i,
  input  logic [7:0]        status_i,
  output logic              data_o,
  output logic              frame_end_o,
  output logic [7:0]        op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  nbits_o
);
  import flash_erase_pkg::*;

  localparam int SH_W = ADDR_W + 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0] s1_q, s2_q; // {cs, sclk, data}
  logic       sclk_prev_q, cs_prev_q;
  logic       cs_s, sclk_s, din_s, rise, fall;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] nbits_q;
  logic [2:0]       ph_q;
  logic [7:0]       op_q, tx_q;
  logic             dout_q, rdsr_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 3'b100;
      s2_q <= 3'b100;
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
    end else begin
      s1_q <= {cs_ni, sclk_i, data_i};
      s2_q <= s1_q;
      sclk_prev_q <= s2_q[1];
      cs_prev_q   <= s2_q[2];
    end
  end

  assign cs_s   = s2_q[2];
  assign sclk_s = s2_q[1];
  assign din_s  = s2_q[0];
  assign rise   = sclk_s & ~sclk_prev_q & ~cs_s;
  assign fall   = ~sclk_s & sclk_prev_q & ~cs_s;
  assign frame_end_o = cs_s & ~cs_prev_q;
  assign rdsr_act = (nbits_q >= CNT_W'(8)) && (op_q == OP_RDSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      nbits_q <= '0;
      ph_q <= '0;
      op_q <= '0;
    end else if (cs_s) begin
      nbits_q <= '0;
      ph_q <= '0;
    end else if (rise) begin
      sh_q <= {sh_q[SH_W-2:0], din_s};
      ph_q <= ph_q + 3'd1;
      if (nbits_q != CNT_MAX) nbits_q <= nbits_q + CNT_W'(1);
      if (nbits_q == CNT_W'(7)) op_q <= {sh_q[6:0], din_s};
    end
  end

  // status is re-sampled at each byte boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      dout_q <= 1'b0;
    end else if (cs_s) begin
      dout_q <= 1'b0;
    end else if (fall && rdsr_act) begin
      if (ph_q == 3'd0) begin
        dout_q <= status_i[7];
        tx_q   <= {status_i[6:0], 1'b0};
      end else begin
        dout_q <= tx_q[7];
        tx_q   <= {tx_q[6:0], 1'b0};
      end
    end
  end

  assign data_o  = dout_q;
  assign op_o    = op_q;
  assign addr_o  = sh_q[ADDR_W-1:0];
  assign nbits_o = nbits_q;

  assert_quiet_deselected_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !data_o);
  assert_count_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> nbits_o == '0);
endmodule

// File: rtl/bp_guard.sv
module bp_guard #(
  parameter int ADDR_W  = 24,
  parameter int MEM_AW  = 19,
  parameter int BLOCK_W = 16
) (
  input  logic [2:0]                  bp_i,
  input  flash_erase_pkg::erase_kind_e kind_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic                        blocked_o
);
  import flash_erase_pkg::*;

  localparam int BLK_IW = MEM_AW - BLOCK_W;
  localparam logic [BLK_IW:0] NUM_BLK = (BLK_IW+1)'(1) << BLK_IW;

  logic [BLK_IW:0] prot_n, blk_idx;

  always_comb begin
    if (bp_i == 3'd0) prot_n = '0;
    else if (int'(bp_i) - 1 >= BLK_IW) prot_n = NUM_BLK;
    else prot_n = (BLK_IW+1)'(1) << (bp_i - 3'd1);
  end

  assign blk_idx = {1'b0, addr_i[MEM_AW-1:BLOCK_W]};

  always_comb begin
    unique case (kind_i)
      KIND_CHIP:               blocked_o = (bp_i != 3'd0);
      KIND_SECTOR, KIND_BLOCK: blocked_o = (prot_n != '0) && (blk_idx >= NUM_BLK - prot_n);
      default:                 blocked_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl #(
  parameter int ADDR_W   = 24,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 16,
  parameter int CNT_W    = 6,
  parameter int SE_CYC   = 4000,
  parameter int BE_CYC   = 16000,
  parameter int CE_CYC   = 60000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         frame_end_i,
  input  logic [7:0]                   op_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [CNT_W-1:0]             nbits_i,
  input  logic                         blocked_i,
  output flash_erase_pkg::erase_kind_e cand_o,
  output logic                         wel_o,
  output logic                         wip_o,
  output flash_erase_pkg::erase_kind_e kind_o,
  output logic [ADDR_W-1:0]            base_o
);
  import flash_erase_pkg::*;

  localparam int MAX_A = (SE_CYC > BE_CYC) ? SE_CYC : BE_CYC;
  localparam int MAX_C = (MAX_A > CE_CYC) ? MAX_A : CE_CYC;
  localparam int TW    = $clog2(MAX_C + 1);
  localparam logic [ADDR_W-1:0] SEC_MASK = ~((ADDR_W'(1) << SECTOR_W) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << BLOCK_W) - ADDR_W'(1));

  erase_kind_e cand, kind_q;
  logic [TW-1:0] tmr_q, load_val;
  logic [ADDR_W-1:0] base_d, base_q;
  logic wel_q, wip_q, start, wren;

  always_comb begin
    cand = KIND_NONE;
    if (nbits_i == CNT_W'(ADDR_W + 8)) begin
      if (op_i == OP_SE) cand = KIND_SECTOR;
      else if (op_i == OP_BE) cand = KIND_BLOCK;
    end else if (nbits_i == CNT_W'(8)) begin
      if (op_i == OP_CE_A || op_i == OP_CE_B) cand = KIND_CHIP;
    end
  end

  always_comb begin
    unique case (cand)
      KIND_SECTOR: begin base_d = addr_i & SEC_MASK; load_val = TW'(SE_CYC - 1); end
      KIND_BLOCK:  begin base_d = addr_i & BLK_MASK; load_val = TW'(BE_CYC - 1); end
      KIND_CHIP:   begin base_d = '0;                load_val = TW'(CE_CYC - 1); end
      default:     begin base_d = '0;                load_val = '0; end
    endcase
  end

  assign start = frame_end_i && !wip_q && wel_q && (cand != KIND_NONE) && !blocked_i;
  assign wren  = frame_end_i && !wip_q && (nbits_i == CNT_W'(8)) && (op_i == OP_WREN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
      wip_q <= 1'b0;
      tmr_q <= '0;
      kind_q <= KIND_NONE;
      base_q <= '0;
    end else if (start) begin
      wip_q <= 1'b1;
      tmr_q <= load_val;
      kind_q <= cand;
      base_q <= base_d;
    end else if (wip_q) begin
      if (tmr_q == '0) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
        kind_q <= KIND_NONE;
        base_q <= '0;
      end else begin
        tmr_q <= tmr_q - TW'(1);
      end
    end else if (wren) begin
      wel_q <= 1'b1;
    end
  end

  assign cand_o = cand;
  assign wel_o  = wel_q;
  assign wip_o  = wip_q;
  assign kind_o = kind_q;
  assign base_o = base_q;

  assert_busy_implies_wel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_q |-> wel_q);
  assert_done_clears_wel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_q) |-> !wel_q);
  assert_start_needs_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> $past(frame_end_i));
  assert_job_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wip_q && $past(wip_q)) |-> ($stable(kind_q) && $stable(base_q)));
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl #(
  parameter int ADDR_W   = 24,
  parameter int MEM_AW   = 19,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 16,
  parameter int SE_CYC   = 4000,
  parameter int BE_CYC   = 16000,
  parameter int CE_CYC   = 60000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              data_i,
  output logic              data_o,
  input  logic [2:0]        bp_i,
  output logic              erase_req_o,
  output logic [1:0]        erase_kind_o,
  output logic [ADDR_W-1:0] erase_base_o
);
  import flash_erase_pkg::*;

  localparam int CNT_W = $clog2(ADDR_W + 8) + 1;

  logic frame_end, blocked, wel, wip;
  logic [7:0] op, status;
  logic [ADDR_W-1:0] addr, base;
  logic [CNT_W-1:0] nbits;
  erase_kind_e cand, kind;

  assign status = {3'b000, bp_i, wel, wip};

  spi_frame_rx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .data_i,
    .status_i(status), .data_o,
    .frame_end_o(frame_end), .op_o(op), .addr_o(addr), .nbits_o(nbits)
  );

  bp_guard #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .BLOCK_W(BLOCK_W)) u_guard (
    .bp_i, .kind_i(cand), .addr_i(addr), .blocked_o(blocked)
  );

  erase_ctrl #(
    .ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W), .CNT_W(CNT_W),
    .SE_CYC(SE_CYC), .BE_CYC(BE_CYC), .CE_CYC(CE_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni, .frame_end_i(frame_end), .op_i(op), .addr_i(addr),
    .nbits_i(nbits), .blocked_i(blocked), .cand_o(cand),
    .wel_o(wel), .wip_o(wip), .kind_o(kind), .base_o(base)
  );

  assign erase_req_o  = wip;
  assign erase_kind_o = kind;
  assign erase_base_o = base;

  assert_chip_unprotected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(erase_req_o) && erase_kind_o == 2'd3) |-> $past(bp_i) == 3'd0);
  assert_kind_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> erase_kind_o != 2'd0);
endmodule

// File: tb/flash_erase_ctrl_tb_top.sv
module flash_erase_ctrl_tb_top;
  localparam int SE_C = 1500, BE_C = 2000, CE_C = 2500;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [2:0] bp = 3'd0;
  logic dout, req;
  logic [1:0] kind;
  logic [23:0] base;

  always #4 clk = ~clk;

  flash_erase_ctrl #(.SE_CYC(SE_C), .BE_CYC(BE_C), .CE_CYC(CE_C)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .data_i(din),
    .data_o(dout), .bp_i(bp), .erase_req_o(req), .erase_kind_o(kind), .erase_base_o(base)
  );

  typedef struct { logic [1:0] k; logic [23:0] b; int d; } ev_t;
  ev_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic send(int mode, logic [39:0] d, int n);
    sclk = (mode == 3); cs_n = 1'b1; w(H);
    cs_n = 1'b0; w(H);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; din = d[i]; w(H);
      sclk = 1'b1; w(H);
    end
    if (mode == 0) begin sclk = 1'b0; w(H); end
    cs_n = 1'b1; w(2 * H);
  endtask

  task automatic rdsr(int mode, output logic [7:0] b0, output logic [7:0] b1);
    logic [15:0] r;
    sclk = (mode == 3); w(H);
    cs_n = 1'b0; w(H);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; din = 8'h05 >> i; w(H);
      sclk = 1'b1; w(H);
    end
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b0; w(H);
      r[i] = dout;
      sclk = 1'b1; w(H);
    end
    if (mode == 0) begin sclk = 1'b0; w(H); end
    cs_n = 1'b1; w(2 * H);
    b0 = r[15:8]; b1 = r[7:0];
  endtask

  task automatic stat(string r, logic [7:0] exp);
    logic [7:0] a, b;
    rdsr(0, a, b);
    chk(r, {24'd0, a}, {24'd0, exp});
  endtask

  task automatic expect_ev(logic [1:0] k, logic [23:0] b, int d);
    ev_t e; e.k = k; e.b = b; e.d = d;
    exp_q.push_back(e);
  endtask

  task automatic wait_idle(string r);
    logic [7:0] a, b;
    int n = 0;
    do begin rdsr(n % 2 == 0 ? 0 : 3, a, b); n++; end while (a[0] && n < 200);
    chk(r, {24'd0, a}, {24'd0, 3'b000, bp, 2'b00});
  endtask

  // monitor: pops expected erases and compares kind, base, duration
  initial begin
    forever begin
      @(posedge req);
      @(negedge clk);
      begin
        logic [1:0] k; logic [23:0] b; int n;
        k = kind; b = base; n = 0;
        while (req) begin n++; @(negedge clk); end
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3/R8 unexpected erase actual=%0h expected=none", b);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk("R10 kind", {30'd0, k}, {30'd0, e.k});
          chk("R10 base", {8'd0, b}, {8'd0, e.b});
          chk("R5 duration", n, e.d);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b;
    w(5); rst_n = 1'b1; w(5);
    chk("R5 reset request", {31'd0, req}, 32'd0);
    stat("R7 reset status", 8'h00);
    chk("R7 deselected output", {31'd0, dout}, 32'd0);

    send(0, 40'h20_012345, 32);
    w(20);
    stat("R3 erase without latch", 8'h00);

    send(0, 40'h06, 9);
    stat("R2 wrong length write enable", 8'h00);
    send(3, 40'h06, 8);
    stat("R1 R2 mode3 write enable", 8'h02);

    send(0, 40'h20_012345 >> 1, 31);
    stat("R4 short sector erase", 8'h02);
    send(3, 40'h20_012345_00, 40);
    stat("R4 long sector erase", 8'h02);

    expect_ev(2'd1, 24'h012000, SE_C);
    send(0, 40'h20_012345, 32);
    rdsr(3, a, b);
    chk("R7 busy status byte0", {24'd0, a}, 32'h03);
    chk("R7 busy status byte1", {24'd0, b}, 32'h03);
    send(0, 40'hD8_030000, 32);
    send(0, 40'h06, 8);
    wait_idle("R6 sector done");

    bp = 3'd1;
    send(0, 40'h06, 8);
    send(3, 40'hD8_07ABCD, 32);
    w(20);
    stat("R9 protected block refused", 8'h06);
    expect_ev(2'd2, 24'h030000, BE_C);
    send(3, 40'hD8_03ABCD, 32);
    wait_idle("R6 block done");

    bp = 3'd2;
    send(0, 40'h06, 8);
    send(0, 40'h20_060000, 32);
    w(20);
    stat("R9 sector in second protected block", 8'h0A);
    send(0, 40'h60, 8);
    w(20);
    stat("R9 chip erase under protection", 8'h0A);
    expect_ev(2'd1, 24'h05F000, SE_C);
    send(3, 40'h20_05FFFF, 32);
    wait_idle("R6 sector below boundary");

    bp = 3'd0;
    send(3, 40'h06, 8);
    send(0, 40'hC7 << 1, 9);
    stat("R4 chip erase wrong length", 8'h02);
    expect_ev(2'd3, 24'h000000, CE_C);
    send(0, 40'hC7, 8);
    send(3, 40'h06, 8);
    send(3, 40'h60, 8);
    wait_idle("R8 chip done no restart");

    send(0, 40'h06, 8);
    expect_ev(2'd3, 24'h000000, CE_C);
    send(3, 40'h60, 8);
    wait_idle("R1 mode3 chip erase");

    w(50);
    chk("R8 no pending erases", exp_q.size(), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule